// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register bank for a single DMA channel. It sits on a 32-bit memory-mapped slave port and holds four words: a control/status word, a transfer address, a byte count and an upper-address base. The data mover, the bus master and the attached peripheral are outside the block. The block connects to them only through a few side-band signals.

The peripheral's interrupt level is latched into a pending bit. That bit is gated by an enable bit onto the CPU interrupt line. A control write can send a one-cycle reset pulse to the peripheral, and the channel enable bit drives a level-type enable output. Any write to the address register raises a loaded flag in the control word. The address register also advances by a burst length each time the channel reports a finished burst.

Top module: `dma_chan_regs`

## Requirements
- R1: After synchronous reset the control word reads 0xA0000000, the address, count and base words read 0, and `cpu_irq`, `periph_rst` and `periph_en` are low.
- R2: The word index is `bus_addr[3:2]` (0 control, 1 address, 2 count, 3 base). Higher address bits are ignored, so the 16-byte window repeats. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R3: `cpu_irq` is high exactly when control bit 0 (pending) and bit 4 (interrupt enable) are both set.
- R4: Control bit 0 takes the value of `periph_irq` one cycle later, whatever the CPU writes to it.
- R5: A CPU write never changes control bits under mask 0xFE000007. Bits 31:27 and 25 always read the version code 0xA0000000, and bits 2:1 read 0.
- R6: A control write with bit 7 set drives `periph_rst` high for exactly the one cycle after the write.
- R7: In a control write with bit 7 clear and bit 6 set, bit 6 is stored as 0. If the whole written value is 0, bit 6 is stored as 1. Other written values store bit 6 as given.
- R8: Control bit 9 is the channel enable. `periph_en` goes high when it changes from 0 to 1, goes low when it changes from 1 to 0, and changes only after a control write.
- R9: Any write to word 1 sets control bit 26 (loaded). That bit then stays set across control writes until reset.
- R10: Control bit 8 (transfer direction, 1 = toward memory) and the other writable bits 24:3 read back as written, apart from bit 6 as given in R7.
- R11: When `inc_valid` is high, `inc_len` is added to the address word. A CPU write to word 1 in the same cycle takes priority over the increment.
- R12: Reads have no side effects. Reading any word leaves every register and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, full 32-bit word |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| periph_irq | input | 1 | Interrupt level from the peripheral |
| cpu_irq | output | 1 | Gated interrupt to the CPU |
| periph_rst | output | 1 | One-cycle reset pulse to the peripheral |
| periph_en | output | 1 | DMA enable level to the peripheral |
| inc_valid | input | 1 | A burst has completed |
| inc_len | input | INC_W | Byte length of the completed burst |

## Verification
The bench targets the drain-bit quirk: writing exactly 0 must read back with bit 6 set, and writing bit 6 alone must read it back cleared. A design that copied the value straight through, or tested the cases in the wrong order, would return the written bit 6. It writes all ones to the control word to show that the read-only mask holds the version and the pending bit, and that the same write still fires the reset pulse. It checks that the loaded flag survives later control writes, and that a CPU address write beats a simultaneous increment. It also checks that the interrupt output stays low while the enable is off even though pending is set. A design that got these wrong would lose the flag, add the increment to the written value, or leak the interrupt.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] RO_MASK = 32'hFE000007;
  localparam int unsigned B_PEND   = 0;
  localparam int unsigned B_IEN    = 4;
  localparam int unsigned B_DRAIN  = 6;
  localparam int unsigned B_PRST   = 7;
  localparam int unsigned B_TOMEM  = 8;
  localparam int unsigned B_DEN    = 9;
  localparam int unsigned B_LOADED = 26;
  typedef enum logic [1:0] {
    IDX_CTL   = 2'd0,
    IDX_ADDR  = 2'd1,
    IDX_COUNT = 2'd2,
    IDX_BASE  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/dma_ctl_word.sv
module dma_ctl_word
  import dma_regs_pkg::*;
#(
  parameter logic [WORD_W-1:0] VERSION = 32'hA0000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl,
  input  logic              wr_addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              periph_irq,
  output logic [WORD_W-1:0] ctl_q,
  output logic              cpu_irq,
  output logic              periph_rst,
  output logic              periph_en
);
  logic [WORD_W-1:0] shaped;
  logic [WORD_W-1:0] ctl_d;

  // Drain bit quirk: the reset request has priority, then drain, then all-zero.
  always_comb begin
    shaped = wdata;
    if (wdata[B_PRST]) begin
      shaped = wdata;
    end else if (wdata[B_DRAIN]) begin
      shaped[B_DRAIN] = 1'b0;
    end else if (wdata == '0) begin
      shaped[B_DRAIN] = 1'b1;
    end
  end

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) ctl_d = (ctl_q & RO_MASK) | (shaped & ~RO_MASK) | VERSION;
    if (wr_addr) ctl_d[B_LOADED] = 1'b1;
    ctl_d[B_PEND] = periph_irq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= VERSION;
      periph_rst <= 1'b0;
    end else begin
      ctl_q      <= ctl_d;
      periph_rst <= wr_ctl & wdata[B_PRST];
    end
  end

  assign cpu_irq   = ctl_q[B_PEND] & ctl_q[B_IEN];
  assign periph_en = ctl_q[B_DEN];
endmodule

// File: rtl/dma_data_regs.sv
module dma_data_regs
  import dma_regs_pkg::*;
#(
  parameter int unsigned INC_W = 16,
  parameter int unsigned NREG  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREG-1:0]             wr_sel,
  input  logic [WORD_W-1:0]           wdata,
  input  logic                        inc_valid,
  input  logic [INC_W-1:0]            inc_len,
  output logic [NREG-1:0][WORD_W-1:0] regs_q
);
  // Slot k holds word index k+1; only the address word advances.
  for (genvar k = 0; k < NREG; k++) begin : g_word
    if (k + 1 == int'(IDX_ADDR)) begin : g_counting
      always_ff @(posedge clk) begin
        if (rst) regs_q[k] <= '0;
        else if (wr_sel[k]) regs_q[k] <= wdata;
        else if (inc_valid) regs_q[k] <= regs_q[k] + WORD_W'(inc_len);
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) regs_q[k] <= '0;
        else if (wr_sel[k]) regs_q[k] <= wdata;
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 8,
  parameter int unsigned       INC_W   = 16,
  parameter logic [31:0]       VERSION = 32'hA0000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              periph_irq,
  output logic              cpu_irq,
  output logic              periph_rst,
  output logic              periph_en,
  input  logic              inc_valid,
  input  logic [INC_W-1:0]  inc_len
);
  localparam int unsigned NDATA = 3;

  reg_idx_e                       idx;
  logic [WORD_W-1:0]              ctl_q;
  logic [NDATA-1:0]               wr_sel;
  logic [NDATA-1:0][WORD_W-1:0]   data_q;

  assign idx = reg_idx_e'(bus_addr[3:2]);

  always_comb begin
    for (int k = 0; k < NDATA; k++) wr_sel[k] = bus_wr && (int'(idx) == k + 1);
  end

  dma_ctl_word #(.VERSION(VERSION)) u_ctl (
    .clk(clk), .rst(rst),
    .wr_ctl(bus_wr && idx == IDX_CTL),
    .wr_addr(bus_wr && idx == IDX_ADDR),
    .wdata(bus_wdata), .periph_irq(periph_irq),
    .ctl_q(ctl_q), .cpu_irq(cpu_irq),
    .periph_rst(periph_rst), .periph_en(periph_en)
  );

  dma_data_regs #(.INC_W(INC_W), .NREG(NDATA)) u_data (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wdata(bus_wdata),
    .inc_valid(inc_valid), .inc_len(inc_len), .regs_q(data_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (idx)
        IDX_CTL:   bus_rdata <= ctl_q;
        IDX_ADDR:  bus_rdata <= data_q[0];
        IDX_COUNT: bus_rdata <= data_q[1];
        default:   bus_rdata <= data_q[2];
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [31:0] VERSION = 32'hA0000000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              periph_irq,
  input logic              cpu_irq,
  input logic              periph_rst,
  input logic              periph_en,
  input logic [31:0]       ctl_q
);
  logic ctl_wr, addr_wr;
  assign ctl_wr  = bus_wr && bus_addr[3:2] == 2'd0;
  assign addr_wr = bus_wr && bus_addr[3:2] == 2'd1;

  a_r3_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (periph_irq && ctl_wr && bus_wdata[4]) |=> cpu_irq);
  a_r4_irq_drop: assert property (@(posedge clk) disable iff (rst)
    !periph_irq |=> !cpu_irq);
  a_r5_version: assert property (@(posedge clk) disable iff (rst)
    ctl_q[31:27] == VERSION[31:27] && ctl_q[25] == VERSION[25] && ctl_q[2:1] == 2'b00);
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    periph_rst |-> $past(ctl_wr && bus_wdata[7]));
  a_r6_pulse_fire: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && bus_wdata[7]) |=> periph_rst);
  a_r8_en_cause: assert property (@(posedge clk) disable iff (rst)
    !$stable(periph_en) |-> $past(ctl_wr));
  a_r9_loaded: assert property (@(posedge clk) disable iff (rst)
    addr_wr |=> ctl_q[26]);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .periph_irq(periph_irq), .cpu_irq(cpu_irq),
  .periph_rst(periph_rst), .periph_en(periph_en), .ctl_q(ctl_q)
);

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned INC_W  = 16;
  localparam logic [31:0] VER = 32'hA0000000;
  localparam logic [31:0] ROM = 32'hFE000007;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic periph_irq = 1'b0, cpu_irq, periph_rst, periph_en;
  logic inc_valid = 1'b0;
  logic [INC_W-1:0] inc_len = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dma_chan_regs #(.ADDR_W(ADDR_W), .INC_W(INC_W), .VERSION(VER)) i_dma_chan_regs (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl_after(input logic [31:0] old, input logic [31:0] v);
    logic [31:0] x = v;
    if (x[7]) x = v;
    else if (x[6]) x[6] = 1'b0;
    else if (x == 0) x[6] = 1'b1;
    return (old & ROM) | (x & ~ROM) | VER;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); check("R1 ctl", d, VER);
    rd(8'h04, d); check("R1 addr", d, 0);
    rd(8'h08, d); check("R1 count", d, 0);
    rd(8'h0C, d); check("R1 base", d, 0);
    check("R1 outs", {cpu_irq, periph_rst, periph_en}, 0);
    rd(8'h04, d); rd(8'h00, d);
    check("R12 read leaves loaded clear", d, VER);
  endtask

  task automatic t_alias;
    logic [31:0] d;
    wr(8'h18, 32'h1234_5678);
    rd(8'h08, d); check("R2 alias count", d, 32'h1234_5678);
    wr(8'hFC, 32'hCAFE_0000);
    rd(8'h0C, d); check("R2 alias base", d, 32'hCAFE_0000);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(8'h00, 32'h0);
    periph_irq = 1'b1; @(negedge clk);
    check("R3 gated off", cpu_irq, 0);
    rd(8'h00, d); check("R4 pending set", d[0], 1);
    wr(8'h00, 32'h10); check("R3 gated on", cpu_irq, 1);
    wr(8'h00, 32'h11); rd(8'h00, d); check("R4 cpu cannot clear", d[0], 1);
    periph_irq = 1'b0; @(negedge clk);
    check("R4 level low drops irq", cpu_irq, 0);
    rd(8'h00, d); check("R4 pending cleared", d[0], 0);
  endtask

  task automatic t_drain;
    logic [31:0] old, d;
    rd(8'h00, old); wr(8'h00, 32'h40); rd(8'h00, d);
    check("R7 drain stored 0", d, ctl_after(old, 32'h40));
    check("R7 drain bit", d[6], 0);
    wr(8'h00, 32'h0); rd(8'h00, d); check("R7 zero sets drain", d[6], 1);
    wr(8'h00, 32'h50); rd(8'h00, d); check("R7 drain with ien", d[6:4], 3'b001);
    wr(8'h00, 32'hC0); rd(8'h00, d); check("R7 reset keeps drain", d[7:6], 2'b11);
  endtask

  task automatic t_pulse;
    wr(8'h00, 32'h80);
    check("R6 pulse high", periph_rst, 1);
    @(negedge clk); check("R6 pulse one cycle", periph_rst, 0);
    wr(8'h00, 32'h10); check("R6 no pulse", periph_rst, 0);
  endtask

  task automatic t_enable;
    wr(8'h00, 32'h200); check("R8 enable rise", periph_en, 1);
    wr(8'h00, 32'h210); check("R8 enable held", periph_en, 1);
    wr(8'h08, 32'h0);   check("R8 other write no change", periph_en, 1);
    wr(8'h00, 32'h40);  check("R8 enable fall", periph_en, 0);
  endtask

  task automatic t_ro;
    logic [31:0] old, d;
    rd(8'h00, old); wr(8'h00, 32'hFFFF_FFFF);
    check("R6 pulse on all-ones", periph_rst, 1);
    rd(8'h00, d); check("R5 read-only held", d, ctl_after(old, 32'hFFFF_FFFF));
    check("R5 top bits", d & 32'hFA000006, VER);
  endtask

  task automatic t_loaded;
    logic [31:0] d;
    rd(8'h00, d); check("R9 loaded clear before", d[26], 0);
    wr(8'h24, 32'h0000_1000);
    rd(8'h00, d); check("R9 loaded set", d[26], 1);
    wr(8'h00, 32'h0); rd(8'h00, d); check("R9 loaded survives", d, 32'hA400_0040);
  endtask

  task automatic t_dir;
    logic [31:0] d;
    wr(8'h00, 32'h0000_0100); rd(8'h00, d); check("R10 direction bit", d, 32'hA400_0100);
    wr(8'h00, 32'h01AB_CD08); rd(8'h00, d); check("R10 writable bits", d, 32'hA5AB_CD08);
  endtask

  task automatic t_inc;
    logic [31:0] d;
    wr(8'h04, 32'h0000_1000);
    inc_len = 16'h0020; inc_valid = 1'b1; @(negedge clk); inc_valid = 1'b0;
    rd(8'h04, d); check("R11 increment", d, 32'h0000_1020);
    inc_len = 16'hFFFF; inc_valid = 1'b1; @(negedge clk); inc_valid = 1'b0;
    rd(8'h04, d); check("R11 wide increment", d, 32'h0001_101F);
    inc_valid = 1'b1; wr(8'h04, 32'h0000_5000); inc_valid = 1'b0;
    rd(8'h04, d); check("R11 cpu write wins", d, 32'h0000_5000);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_alias();
    t_irq();
    t_drain();
    t_pulse();
    t_enable();
    t_ro();
    wr(8'h00, 32'h0);
    t_loaded();
    t_dir();
    t_inc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule